// File: doc/BRIEF.md
# PWM Event Action Generator

This block drives one pulse-width-modulated output from a shared timebase that lives outside it. Each cycle the timebase presents its counter value, its counting direction and two flags that mark the counter at zero and at its period. The block compares the counter against two compare values, A and B. It turns each event it detects into an action on the output. The action depends on which event occurred and on the direction the counter was moving.

Software programs the block through a small write port. A packed action word gives every event a 2-bit action code, separately for up-counting and down-counting. Each compare value is written into a shadow register. It moves into the active register either at once or at chosen points of the counter cycle. The active compare values are visible on output ports. Typical presets are "high from zero until compare" for an up-only counter, and "high between the down-count and up-count compare matches" for an up-down counter.

Top module: `pwm_action_gen`

## Requirements
- R1: An action code applied to the output takes effect on the next clock edge. Code 0 leaves the output alone, 1 drives it low, 2 drives it high and 3 inverts it. When no event occurs, the output holds.
- R2: While `tb_up` is 1, the codes come from these bit positions of the action word: zero at [1:0], period at [3:2], compare-A match at [5:4] and compare-B match at [7:6].
- R3: While `tb_up` is 0, the codes come from these bit positions: zero at [13:12], period at [15:14], compare-A at [17:16] and compare-B at [19:18].
- R4: When several events share a cycle, the first nonzero code wins, in this order: compare-B, compare-A, period, zero.
- R5: Action word bits [11:8] and [31:20] have no effect on the output.
- R6: `cfg_sel` chooses the target of a write: 0 is the action word, 1 is compare A (`cfg_wdata[15:0]`), 2 is compare B and 3 is the update method (`cfg_wdata[1:0]`). When the update method is 0, a compare write becomes active on the next edge.
- R7: When update-method bit 0 is set, the shadowed compare loads into the active register at an edge where `tb_zero` is 1.
- R8: When update-method bit 1 is set, the load happens at an edge where `tb_peak` is 1. With both bits set, either flag loads.
- R9: `cmp_a_act` and `cmp_b_act` show the active compare values and never a pending shadow value. Matches are taken against these active values.
- R10: After reset the output is low. Both compare values, the action word and the update method are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_cnt | input | 16 | Timebase counter value |
| tb_up | input | 1 | 1 while the timebase counts up |
| tb_zero | input | 1 | Timebase counter at zero |
| tb_peak | input | 1 | Timebase counter at period |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cmp_a_act | output | 16 | Active compare A |
| cmp_b_act | output | 16 | Active compare B |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume that the timebase flags agree with the counting mode. They also assume that a cycle with neither flag set leaves the active compares alone unless an immediate write is in flight. The assertions do not require the flags to be consistent with `tb_cnt`, so the stimulus may raise zero and period together. This is done to probe priority. Each stimulus vector drives counter, direction, flags and an optional write at the falling edge. A reference model computes the expected output and compare readback from the same vector, and a monitor compares them just after the following rising edge.

// File: rtl/pwm_action_gen.sv
module pwm_action_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tb_cnt,
  input  logic         tb_up,
  input  logic         tb_zero,
  input  logic         tb_peak,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_sel,
  input  logic [31:0]  cfg_wdata,
  output logic [W-1:0] cmp_a_act,
  output logic [W-1:0] cmp_b_act,
  output logic         pwm_out
);

  localparam logic [1:0] SEL_ACT  = 2'd0;
  localparam logic [1:0] SEL_CMPA = 2'd1;
  localparam logic [1:0] SEL_CMPB = 2'd2;
  localparam logic [1:0] SEL_METH = 2'd3;

  logic [15:0]  act_q;
  logic [1:0]   meth_q;
  logic [W-1:0] sh_a, sh_b, sh_a_nx, sh_b_nx;
  logic [7:0]   dir_act;
  logic [1:0]   c_z, c_p, c_a, c_b, code;
  logic         wr_a, wr_b, load, pwm_nx;
  logic         unused_bits;

  assign unused_bits = ^{cfg_wdata[31:20], cfg_wdata[11:8]};

  assign wr_a = cfg_we && cfg_sel == SEL_CMPA;
  assign wr_b = cfg_we && cfg_sel == SEL_CMPB;
  assign sh_a_nx = wr_a ? cfg_wdata[W-1:0] : sh_a;
  assign sh_b_nx = wr_b ? cfg_wdata[W-1:0] : sh_b;
  assign load = (tb_zero && meth_q[0]) || (tb_peak && meth_q[1]);

  assign dir_act = tb_up ? act_q[7:0] : act_q[15:8];
  assign c_z = tb_zero               ? dir_act[1:0] : 2'd0;
  assign c_p = tb_peak               ? dir_act[3:2] : 2'd0;
  assign c_a = (tb_cnt == cmp_a_act) ? dir_act[5:4] : 2'd0;
  assign c_b = (tb_cnt == cmp_b_act) ? dir_act[7:6] : 2'd0;
  assign code = (c_b != 2'd0) ? c_b :
                (c_a != 2'd0) ? c_a :
                (c_p != 2'd0) ? c_p : c_z;

  always_comb begin
    case (code)
      2'd1:    pwm_nx = 1'b0;
      2'd2:    pwm_nx = 1'b1;
      2'd3:    pwm_nx = ~pwm_out;
      default: pwm_nx = pwm_out;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q     <= '0;
      meth_q    <= '0;
      sh_a      <= '0;
      sh_b      <= '0;
      cmp_a_act <= '0;
      cmp_b_act <= '0;
      pwm_out   <= 1'b0;
    end else begin
      pwm_out <= pwm_nx;
      sh_a    <= sh_a_nx;
      sh_b    <= sh_b_nx;
      if (cfg_we && cfg_sel == SEL_ACT)  act_q  <= {cfg_wdata[19:12], cfg_wdata[7:0]};
      if (cfg_we && cfg_sel == SEL_METH) meth_q <= cfg_wdata[1:0];
      if (wr_a && meth_q == 2'd0)      cmp_a_act <= cfg_wdata[W-1:0];
      else if (load)                   cmp_a_act <= sh_a_nx;
      if (wr_b && meth_q == 2'd0)      cmp_b_act <= cfg_wdata[W-1:0];
      else if (load)                   cmp_b_act <= sh_b_nx;
    end
  end

endmodule

// File: rtl/pwm_action_gen_chk.sv
module pwm_action_gen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] tb_cnt,
  input logic         tb_up,
  input logic         tb_zero,
  input logic         tb_peak,
  input logic         cfg_we,
  input logic [1:0]   cfg_sel,
  input logic [W-1:0] wdata_lo,
  input logic [W-1:0] cmp_a_act,
  input logic [W-1:0] cmp_b_act,
  input logic         pwm_out,
  input logic [15:0]  act_q,
  input logic [1:0]   meth_q
);

  logic hit_a, hit_b;
  assign hit_a = tb_cnt == cmp_a_act;
  assign hit_b = tb_cnt == cmp_b_act;

  p_quiet_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_zero && !tb_peak && !hit_a && !hit_b) |=> $stable(pwm_out));

  p_up_zero_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_up && tb_zero && !tb_peak && !hit_a && !hit_b && act_q[1:0] == 2'd2) |=> pwm_out);

  p_dn_cmpa_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_up && hit_a && !hit_b && act_q[13:12] == 2'd1) |=> !pwm_out);

  p_cmpb_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_up && hit_b && act_q[7:6] == 2'd1) |=> !pwm_out);

  p_imm_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1 && meth_q == 2'd0) |=> cmp_a_act == $past(wdata_lo));

  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (meth_q != 2'd0 && !tb_zero && !tb_peak) |=> ($stable(cmp_a_act) && $stable(cmp_b_act)));

endmodule

bind pwm_action_gen pwm_action_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tb_cnt(tb_cnt), .tb_up(tb_up), .tb_zero(tb_zero),
  .tb_peak(tb_peak), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .wdata_lo(cfg_wdata[W-1:0]),
  .cmp_a_act(cmp_a_act), .cmp_b_act(cmp_b_act), .pwm_out(pwm_out),
  .act_q(act_q), .meth_q(meth_q)
);

// File: tb/pwm_action_gen_test.sv
module pwm_action_gen_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] tb_cnt = 16'h1234;
  logic        tb_up = 1'b1, tb_zero = 1'b0, tb_peak = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [15:0] cmp_a_act, cmp_b_act;
  logic        pwm_out;

  pwm_action_gen uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic out; logic [15:0] ca; logic [15:0] cb; string tag; } item_t;
  item_t sb[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_act = '0;
  logic [1:0]  m_meth = '0;
  logic [15:0] m_sa = '0, m_sb = '0, m_ca = '0, m_cb = '0;
  logic        m_out = 1'b0;

  function automatic logic [1:0] fld(input logic [31:0] a, input int off);
    return a[off +: 2];
  endfunction

  task automatic step(input logic [15:0] c, input bit up, input bit z, input bit p,
                      input bit we, input logic [1:0] sel, input logic [31:0] d,
                      input string tag);
    int base;
    logic [1:0] cz, cp, cca, ccb, code;
    logic [15:0] nsa, nsb;
    bit ld;
    item_t it;
    tb_cnt = c; tb_up = up; tb_zero = z; tb_peak = p;
    cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    base = up ? 0 : 12;
    cz  = z ? fld(m_act, base) : 2'd0;
    cp  = p ? fld(m_act, base + 2) : 2'd0;
    cca = (c == m_ca) ? fld(m_act, base + 4) : 2'd0;
    ccb = (c == m_cb) ? fld(m_act, base + 6) : 2'd0;
    code = ccb != 0 ? ccb : cca != 0 ? cca : cp != 0 ? cp : cz;
    if (code == 2'd1) m_out = 1'b0;
    else if (code == 2'd2) m_out = 1'b1;
    else if (code == 2'd3) m_out = ~m_out;
    ld  = (z && m_meth[0]) || (p && m_meth[1]);
    nsa = (we && sel == 2'd1) ? d[15:0] : m_sa;
    nsb = (we && sel == 2'd2) ? d[15:0] : m_sb;
    if (we && sel == 2'd1 && m_meth == 0) m_ca = d[15:0]; else if (ld) m_ca = nsa;
    if (we && sel == 2'd2 && m_meth == 0) m_cb = d[15:0]; else if (ld) m_cb = nsb;
    m_sa = nsa; m_sb = nsb;
    if (we && sel == 2'd0) m_act = d;
    if (we && sel == 2'd3) m_meth = d[1:0];
    it.out = m_out; it.ca = m_ca; it.cb = m_cb; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input string tag);
    step(16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, sel, d, tag);
  endtask

  task automatic up_period(input int prd, input string tag);
    for (int i = 0; i <= prd; i++)
      step(16'(i), 1'b1, i == 0, i == prd, 1'b0, 2'd0, '0, tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      n_vec++;
      if (pwm_out !== e.out || cmp_a_act !== e.ca || cmp_b_act !== e.cb) begin
        n_bad++;
        $display("FAIL %s: out=%0b ca=%0d cb=%0d expected out=%0b ca=%0d cb=%0d",
                 e.tag, pwm_out, cmp_a_act, cmp_b_act, e.out, e.ca, e.cb);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    step(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R10");
    // R2 up-only active-high preset, immediate compare (R6)
    wr(2'd3, 32'd0, "R6");
    wr(2'd2, 32'hFFF0, "R6");
    wr(2'd0, 32'h0000_0012, "R2");
    wr(2'd1, 32'd4, "R6");
    up_period(9, "R2"); up_period(9, "R2");
    // R7 load at zero
    wr(2'd3, 32'd1, "R7");
    wr(2'd1, 32'd7, "R9");
    up_period(9, "R7"); up_period(9, "R7");
    // R8 load at period, then both points
    wr(2'd3, 32'd2, "R8");
    wr(2'd1, 32'd2, "R9");
    up_period(9, "R8"); up_period(9, "R8");
    wr(2'd3, 32'd3, "R8");
    wr(2'd1, 32'd5, "R9");
    up_period(9, "R8");
    wr(2'd1, 32'd6, "R9");
    up_period(9, "R8");
    // R3 up-down preset
    wr(2'd3, 32'd0, "R6");
    wr(2'd0, (32'd1 << 4) | (32'd2 << 16), "R3");
    wr(2'd1, 32'd3, "R6");
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 18; i++) begin
        int c;
        c = (i <= 9) ? i : 18 - i;
        step(16'(c), i < 9, c == 0, c == 9, 1'b0, 2'd0, '0, "R3");
      end
    // R4 priority
    wr(2'd0, 32'h0000_0006, "R4");
    step(16'd9, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, '0, "R4");
    wr(2'd0, 32'h0000_0002, "R4");
    step(16'd9, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, '0, "R4");
    wr(2'd1, 32'd9, "R4");
    wr(2'd0, 32'h0000_0018, "R4");
    step(16'd9, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, '0, "R4");
    wr(2'd1, 32'd6, "R4");
    wr(2'd2, 32'd6, "R4");
    wr(2'd0, 32'h0000_0060, "R4");
    step(16'd6, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R4");
    wr(2'd0, 32'h0000_0020, "R4");
    step(16'd6, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R4");
    wr(2'd0, 32'h0008_0000, "R4");
    step(16'd6, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R4");
    // R1 toggle on up period, then on down period
    wr(2'd2, 32'hFFF0, "R1");
    wr(2'd0, 32'h0000_000C, "R1");
    for (int i = 0; i < 5; i++) step(16'd9, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, '0, "R1");
    step(16'd9, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, '0, "R1");
    wr(2'd0, 32'h0000_C000, "R1");
    for (int i = 0; i < 3; i++) step(16'd9, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, '0, "R1");
    // R5 ignored bits
    wr(2'd0, 32'hFFF0_0F00, "R5");
    up_period(9, "R5");
    for (int i = 0; i < 4; i++) step(16'(i), 1'b0, i == 0, 1'b1, 1'b0, 2'd0, '0, "R5");
    step(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, '0, "R5");
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule